// File: doc/BRIEF.md
# Scan Synchronization Marker Generator

This block drives the timing strobes that external equipment uses to follow a raster scan. The scan is built from pixels, lines, frames and Z-stacks. A pixel tick input moves the scan by one pixel. Each line consists of a lead-in stretch, the image pixels and a flyback stretch. Lines are grouped into frames, and frames are grouped into one stack.

Three early-warning strobes are produced, each at a fixed distance ahead of the first image pixel of its own unit:

| Strobe | Fires on | Pixels before first image pixel |
|--------|----------|---------------------------------|
| Line | every line | 44 |
| Frame | first line of each frame | 42 |
| Stack | first line of the first frame | 40 |

A grabbing level marks the image pixels of each line. The strobe offsets are wired into the hardware and cannot be configured. Only the length of the pixel period changes their lead time in absolute terms.

Operation is as follows:
- The geometry is captured when a start command is accepted.
- The scan runs through one full stack and then returns to idle.
- A stop request ends the scan at the end of the current line.
- A start whose lead-in is too short to hold all three strobes is refused, and an error flag is raised.

Top module: `scan_sync_gen`

## Requirements
- R1: While reset is asserted, the following are all zero: every strobe, `grab`, `busy`, `cfg_err`, `pix_pos`, `line_pos` and `frame_pos`.
- R2: A start while idle is accepted when all of these hold: `cfg_lead` >= 44, and `cfg_image`, `cfg_lines` and `cfg_frames` are all nonzero. On the next cycle `busy` is 1, `cfg_err` is 0 and all positions are 0.
- R3: A start while idle that fails the R2 conditions is refused. `busy` stays 0, and `cfg_err` becomes 1 and holds until the next accepted start.
- R4: While busy, each cycle with `pix_en`=1 does the following:
  - `pix_pos` advances by one.
  - After `pix_pos` = lead+image+flyback-1, `pix_pos` returns to 0 and `line_pos` advances.
  - After the last line, `line_pos` returns to 0 and `frame_pos` advances.
  - After the last pixel of the last frame, `busy` drops and all positions return to 0.
  - Cycles with `pix_en`=0 change nothing.
- R5: `line_mark` is 1 exactly while busy with `pix_pos` = lead-44, on every line.
- R6: `frame_mark` is 1 exactly while busy with `line_pos` = 0 and `pix_pos` = lead-42.
- R7: `stack_mark` is 1 exactly while busy with `frame_pos` = 0, `line_pos` = 0 and `pix_pos` = lead-40.
- R8: Each strobe lasts exactly one pixel period, from one `pix_en` tick to the next. At most one strobe is high in any cycle.
- R9: `grab` is 1 exactly while busy with lead <= `pix_pos` < lead+image.
- R10: The geometry inputs are sampled only when a start is accepted. Changing them while busy does not alter the running scan.
- R11: A stop request while busy ends the scan at the end of the line in progress, after its flyback. This includes a stop in the same cycle as that line's final pixel tick. Afterwards `busy` is 0 and no strobe or `grab` is driven.
- R12: A start while busy and a stop while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel tick, one cycle per pixel period |
| start | input | 1 | Start one stack scan |
| stop | input | 1 | Stop at the end of the current line |
| cfg_lead | input | PIX_W | Lead-in pixels per line |
| cfg_image | input | PIX_W | Image pixels per line |
| cfg_flyback | input | PIX_W | Flyback pixels per line |
| cfg_lines | input | LINE_W | Lines per frame |
| cfg_frames | input | FRM_W | Frames per stack |
| line_mark | output | 1 | Line early-warning strobe |
| frame_mark | output | 1 | Frame early-warning strobe |
| stack_mark | output | 1 | Stack early-warning strobe |
| grab | output | 1 | Image pixel gate |
| busy | output | 1 | Scan in progress |
| cfg_err | output | 1 | Last start was refused |
| pix_pos | output | PIX_W+2 | Pixel position within line |
| line_pos | output | LINE_W | Line position within frame |
| frame_pos | output | FRM_W | Frame position within stack |

## Verification
The delicate coincidence is a stop request that lands on the very pixel tick that closes a line. That cycle both wraps the counters and ends the scan, and the design must treat the two as one event.

The bench provokes this by watching its reference model and raising `stop` together with `pix_en` exactly on the final flyback pixel. It then requires `busy` low one cycle later, with no strobe from the following line. A second test starts the scan and fires a new start at the same time as a geometry change. It judges both through the per-clock comparison of positions and strobes against the model, which keeps the first geometry.

// File: rtl/scan_sync_pkg.sv
package scan_sync_pkg;

  // Fixed strobe lead distances in pixel periods (not configurable).
  localparam int unsigned LEAD_LINE  = 44;
  localparam int unsigned LEAD_FRAME = 42;
  localparam int unsigned LEAD_STACK = 40;
  localparam int unsigned LEAD_MIN   = LEAD_LINE;

  localparam int unsigned MK_LINE  = 0;
  localparam int unsigned MK_FRAME = 1;
  localparam int unsigned MK_STACK = 2;
  localparam int unsigned MARK_N   = 3;

  function automatic int unsigned mark_lead(input int unsigned idx);
    case (idx)
      MK_LINE:  return LEAD_LINE;
      MK_FRAME: return LEAD_FRAME;
      default:  return LEAD_STACK;
    endcase
  endfunction

endpackage

// File: rtl/scan_geom_latch.sv
module scan_geom_latch
  import scan_sync_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned FRM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              idle,
  input  logic [PIX_W-1:0]  cfg_lead,
  input  logic [PIX_W-1:0]  cfg_image,
  input  logic [PIX_W-1:0]  cfg_flyback,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [FRM_W-1:0]  cfg_frames,
  output logic              go,
  output logic              cfg_err,
  output logic [PIX_W-1:0]  lead_q,
  output logic [PIX_W-1:0]  image_q,
  output logic [PIX_W-1:0]  fly_q,
  output logic [LINE_W-1:0] lines_q,
  output logic [FRM_W-1:0]  frames_q
);

  localparam logic [PIX_W-1:0] MIN_LEAD = PIX_W'(LEAD_MIN);

  logic              cfg_ok;
  logic              err_d;
  logic [PIX_W-1:0]  lead_d, image_d, fly_d;
  logic [LINE_W-1:0] lines_d;
  logic [FRM_W-1:0]  frames_d;

  always_comb begin
    cfg_ok   = (cfg_lead >= MIN_LEAD) && (cfg_image != '0) &&
               (cfg_lines != '0) && (cfg_frames != '0);
    go       = start & idle & cfg_ok;
    err_d    = cfg_err;
    lead_d   = lead_q;
    image_d  = image_q;
    fly_d    = fly_q;
    lines_d  = lines_q;
    frames_d = frames_q;
    if (start && idle) begin
      err_d = !cfg_ok;
      if (cfg_ok) begin
        lead_d   = cfg_lead;
        image_d  = cfg_image;
        fly_d    = cfg_flyback;
        lines_d  = cfg_lines;
        frames_d = cfg_frames;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err  <= 1'b0;
      lead_q   <= '0;
      image_q  <= '0;
      fly_q    <= '0;
      lines_q  <= '0;
      frames_q <= '0;
    end else begin
      cfg_err  <= err_d;
      lead_q   <= lead_d;
      image_q  <= image_d;
      fly_q    <= fly_d;
      lines_q  <= lines_d;
      frames_q <= frames_d;
    end
  end

  a_r3_short_lead_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && (cfg_lead < MIN_LEAD)) |=> (cfg_err && idle));

  a_r10_geom_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(lead_q) && $stable(image_q) && $stable(fly_q) &&
               $stable(lines_q) && $stable(frames_q)));

endmodule

// File: rtl/scan_pos_counter.sv
module scan_pos_counter #(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned FRM_W  = 6,
  localparam int unsigned POS_W = PIX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              pix_en,
  input  logic              stop,
  input  logic [PIX_W-1:0]  lead_q,
  input  logic [PIX_W-1:0]  image_q,
  input  logic [PIX_W-1:0]  fly_q,
  input  logic [LINE_W-1:0] lines_q,
  input  logic [FRM_W-1:0]  frames_q,
  output logic              running,
  output logic [POS_W-1:0]  pix_pos,
  output logic [LINE_W-1:0] line_pos,
  output logic [FRM_W-1:0]  frame_pos
);

  logic [POS_W-1:0]  line_last;
  logic              at_eol, last_line, last_frame, halt;
  logic              run_d, stop_q, stop_d;
  logic [POS_W-1:0]  pix_d;
  logic [LINE_W-1:0] line_d;
  logic [FRM_W-1:0]  frame_d;

  always_comb begin
    line_last  = POS_W'(lead_q) + POS_W'(image_q) + POS_W'(fly_q) - POS_W'(1);
    at_eol     = (pix_pos == line_last);
    last_line  = (line_pos == lines_q - LINE_W'(1));
    last_frame = (frame_pos == frames_q - FRM_W'(1));
    halt       = stop_q | stop;
    run_d      = running;
    stop_d     = stop_q;
    pix_d      = pix_pos;
    line_d     = line_pos;
    frame_d    = frame_pos;
    if (go) begin
      run_d   = 1'b1;
      stop_d  = 1'b0;
      pix_d   = '0;
      line_d  = '0;
      frame_d = '0;
    end else if (running) begin
      if (stop) stop_d = 1'b1;
      if (pix_en) begin
        if (at_eol) begin
          pix_d = '0;
          if (halt) begin
            run_d   = 1'b0;
            line_d  = '0;
            frame_d = '0;
          end else if (last_line) begin
            line_d = '0;
            if (last_frame) begin
              run_d   = 1'b0;
              frame_d = '0;
            end else begin
              frame_d = frame_pos + FRM_W'(1);
            end
          end else begin
            line_d = line_pos + LINE_W'(1);
          end
        end else begin
          pix_d = pix_pos + POS_W'(1);
        end
      end
      if (!run_d) stop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      stop_q    <= 1'b0;
      pix_pos   <= '0;
      line_pos  <= '0;
      frame_pos <= '0;
    end else begin
      running   <= run_d;
      stop_q    <= stop_d;
      pix_pos   <= pix_d;
      line_pos  <= line_d;
      frame_pos <= frame_d;
    end
  end

  a_r11_no_midline_end: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(pix_en && at_eol)) |=> running);

  a_r4_pix_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pix_pos <= line_last));

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pix_en) |=> ($stable(pix_pos) && $stable(line_pos) && $stable(frame_pos)));

endmodule

// File: rtl/scan_mark_decode.sv
module scan_mark_decode
  import scan_sync_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned FRM_W  = 6,
  localparam int unsigned POS_W = PIX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              running,
  input  logic [POS_W-1:0]  pix_pos,
  input  logic [LINE_W-1:0] line_pos,
  input  logic [FRM_W-1:0]  frame_pos,
  input  logic [PIX_W-1:0]  lead_q,
  input  logic [PIX_W-1:0]  image_q,
  output logic [MARK_N-1:0] marks,
  output logic              grab
);

  logic [MARK_N-1:0] unit_first;
  logic [POS_W-1:0]  img_lo, img_hi;

  always_comb begin
    unit_first[MK_LINE]  = 1'b1;
    unit_first[MK_FRAME] = (line_pos == '0);
    unit_first[MK_STACK] = (line_pos == '0) && (frame_pos == '0);
    img_lo = POS_W'(lead_q);
    img_hi = POS_W'(lead_q) + POS_W'(image_q);
    grab   = running && (pix_pos >= img_lo) && (pix_pos < img_hi);
  end

  for (genvar gi = 0; gi < MARK_N; gi++) begin : g_mark
    localparam logic [POS_W-1:0] OFS = POS_W'(mark_lead(gi));
    logic [POS_W-1:0] target;
    assign target    = POS_W'(lead_q) - OFS;
    assign marks[gi] = running && unit_first[gi] && (pix_pos == target);

    a_r8_one_period: assert property (@(posedge clk) disable iff (!rst_n)
      (marks[gi] && pix_en) |=> !marks[gi]);

    a_r8_held_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      (marks[gi] && !pix_en) |=> marks[gi]);
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(marks));

  a_r9_no_grab_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (marks != '0) |-> !grab);

endmodule

// File: rtl/scan_sync_gen.sv
module scan_sync_gen
  import scan_sync_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned FRM_W  = 6,
  localparam int unsigned POS_W = PIX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              start,
  input  logic              stop,
  input  logic [PIX_W-1:0]  cfg_lead,
  input  logic [PIX_W-1:0]  cfg_image,
  input  logic [PIX_W-1:0]  cfg_flyback,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [FRM_W-1:0]  cfg_frames,
  output logic              line_mark,
  output logic              frame_mark,
  output logic              stack_mark,
  output logic              grab,
  output logic              busy,
  output logic              cfg_err,
  output logic [POS_W-1:0]  pix_pos,
  output logic [LINE_W-1:0] line_pos,
  output logic [FRM_W-1:0]  frame_pos
);

  logic              go, running;
  logic [PIX_W-1:0]  lead_q, image_q, fly_q;
  logic [LINE_W-1:0] lines_q;
  logic [FRM_W-1:0]  frames_q;
  logic [MARK_N-1:0] marks;

  scan_geom_latch #(.PIX_W(PIX_W), .LINE_W(LINE_W), .FRM_W(FRM_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(!running),
    .cfg_lead(cfg_lead), .cfg_image(cfg_image), .cfg_flyback(cfg_flyback),
    .cfg_lines(cfg_lines), .cfg_frames(cfg_frames),
    .go(go), .cfg_err(cfg_err), .lead_q(lead_q), .image_q(image_q),
    .fly_q(fly_q), .lines_q(lines_q), .frames_q(frames_q)
  );

  scan_pos_counter #(.PIX_W(PIX_W), .LINE_W(LINE_W), .FRM_W(FRM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .go(go), .pix_en(pix_en), .stop(stop),
    .lead_q(lead_q), .image_q(image_q), .fly_q(fly_q),
    .lines_q(lines_q), .frames_q(frames_q),
    .running(running), .pix_pos(pix_pos), .line_pos(line_pos),
    .frame_pos(frame_pos)
  );

  scan_mark_decode #(.PIX_W(PIX_W), .LINE_W(LINE_W), .FRM_W(FRM_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .running(running),
    .pix_pos(pix_pos), .line_pos(line_pos), .frame_pos(frame_pos),
    .lead_q(lead_q), .image_q(image_q), .marks(marks), .grab(grab)
  );

  assign line_mark  = marks[MK_LINE];
  assign frame_mark = marks[MK_FRAME];
  assign stack_mark = marks[MK_STACK];
  assign busy       = running;

  a_r12_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !pix_en) |=> ($stable(pix_pos) && $stable(cfg_err)));

endmodule

// File: tb/test_scan_sync_gen.sv
`timescale 1ns/1ps
module test_scan_sync_gen;
  localparam int PIX_W  = 10;
  localparam int LINE_W = 8;
  localparam int FRM_W  = 6;
  localparam int POS_W  = PIX_W + 2;

  logic clk = 1'b0;
  logic rst_n, pix_en, start, stop;
  logic [PIX_W-1:0]  cfg_lead, cfg_image, cfg_flyback;
  logic [LINE_W-1:0] cfg_lines;
  logic [FRM_W-1:0]  cfg_frames;
  logic line_mark, frame_mark, stack_mark, grab, busy, cfg_err;
  logic [POS_W-1:0]  pix_pos;
  logic [LINE_W-1:0] line_pos;
  logic [FRM_W-1:0]  frame_pos;

  always #4 clk = ~clk;

  scan_sync_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W), .FRM_W(FRM_W)) i_scan_sync_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .start(start), .stop(stop),
    .cfg_lead(cfg_lead), .cfg_image(cfg_image), .cfg_flyback(cfg_flyback),
    .cfg_lines(cfg_lines), .cfg_frames(cfg_frames),
    .line_mark(line_mark), .frame_mark(frame_mark), .stack_mark(stack_mark),
    .grab(grab), .busy(busy), .cfg_err(cfg_err), .pix_pos(pix_pos),
    .line_pos(line_pos), .frame_pos(frame_pos)
  );

  int total = 0;
  int bad = 0;
  string pos_tag = "R4";

  // Behavioural reference model state
  int m_run, m_pix, m_line, m_frame, m_stop, m_err;
  int g_lead, g_img, g_fly, g_lines, g_frames;

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    int ok;
    int halt;
    if (!rst_n) begin
      m_run = 0; m_pix = 0; m_line = 0; m_frame = 0; m_stop = 0; m_err = 0;
      g_lead = 0; g_img = 0; g_fly = 0; g_lines = 0; g_frames = 0;
    end else begin
      ok = (int'(cfg_lead) >= 44 && cfg_image != 0 && cfg_lines != 0 && cfg_frames != 0) ? 1 : 0;
      if (m_run == 0) begin
        if (start) begin
          if (ok != 0) begin
            g_lead = int'(cfg_lead); g_img = int'(cfg_image); g_fly = int'(cfg_flyback);
            g_lines = int'(cfg_lines); g_frames = int'(cfg_frames);
            m_run = 1; m_pix = 0; m_line = 0; m_frame = 0; m_stop = 0; m_err = 0;
          end else begin
            m_err = 1;
          end
        end
      end else begin
        halt = (m_stop != 0 || stop) ? 1 : 0;
        if (pix_en) begin
          if (m_pix == g_lead + g_img + g_fly - 1) begin
            m_pix = 0;
            if (halt != 0) begin
              m_run = 0; m_line = 0; m_frame = 0; m_stop = 0;
            end else if (m_line == g_lines - 1) begin
              m_line = 0;
              if (m_frame == g_frames - 1) begin m_run = 0; m_frame = 0; end
              else m_frame++;
            end else m_line++;
          end else m_pix++;
        end
        if (m_run != 0 && stop) m_stop = 1;
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    int e_l, e_f, e_s, e_g;
    e_l = (m_run != 0 && m_pix == g_lead - 44) ? 1 : 0;
    e_f = (m_run != 0 && m_line == 0 && m_pix == g_lead - 42) ? 1 : 0;
    e_s = (m_run != 0 && m_line == 0 && m_frame == 0 && m_pix == g_lead - 40) ? 1 : 0;
    e_g = (m_run != 0 && m_pix >= g_lead && m_pix < g_lead + g_img) ? 1 : 0;
    chk("R5", "line_mark", int'(line_mark), e_l);
    chk("R6", "frame_mark", int'(frame_mark), e_f);
    chk("R7", "stack_mark", int'(stack_mark), e_s);
    chk("R9", "grab", int'(grab), e_g);
    chk("R8", "strobes_high", (int'(line_mark) + int'(frame_mark) + int'(stack_mark)) > 1 ? 1 : 0, 0);
    chk("R3", "cfg_err", int'(cfg_err), m_err);
    chk(pos_tag, "busy", int'(busy), m_run);
    chk(pos_tag, "pix_pos", int'(pix_pos), m_pix);
    chk(pos_tag, "line_pos", int'(line_pos), m_line);
    chk(pos_tag, "frame_pos", int'(frame_pos), m_frame);
  end

  task automatic set_geom(int ld, int im, int fl, int ln, int fr);
    cfg_lead = PIX_W'(ld); cfg_image = PIX_W'(im); cfg_flyback = PIX_W'(fl);
    cfg_lines = LINE_W'(ln); cfg_frames = FRM_W'(fr);
  endtask

  task automatic drive_tick(int mode);
    case (mode)
      0: pix_en = 1'b1;
      1: pix_en = ($urandom_range(0, 2) != 0);
      default: pix_en = ($urandom_range(0, 3) == 0);
    endcase
  endtask

  task automatic run_cycles(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive_tick(mode);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    pix_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_to_idle(int mode);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
      drive_tick(mode);
    end
    pix_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hung expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; start = 1'b0; stop = 1'b0;
    set_geom(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "strobes", int'(line_mark) + int'(frame_mark) + int'(stack_mark) + int'(grab), 0);
    chk("R1", "cfg_err", int'(cfg_err), 0);
    chk("R1", "pix_pos", int'(pix_pos), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 lead one below minimum
    set_geom(43, 5, 3, 2, 1);
    pulse_start();
    chk("R3", "cfg_err short lead", int'(cfg_err), 1);
    chk("R3", "busy short lead", int'(busy), 0);
    // R3 zero line count
    set_geom(60, 5, 3, 0, 1);
    pulse_start();
    chk("R3", "cfg_err zero lines", int'(cfg_err), 1);

    // R12 stop while idle
    pos_tag = "R12";
    @(negedge clk); stop = 1'b1; pix_en = 1'b1;
    @(negedge clk); stop = 1'b0; pix_en = 1'b0;
    @(negedge clk);
    chk("R12", "busy after idle stop", int'(busy), 0);
    chk("R12", "cfg_err after idle stop", int'(cfg_err), 1);

    // Minimum lead: line strobe on pixel 0
    pos_tag = "R4";
    set_geom(44, 5, 3, 3, 2);
    pulse_start();
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "cfg_err after start", int'(cfg_err), 0);
    chk("R2", "pix_pos after start", int'(pix_pos), 0);
    chk("R5", "line_mark at minimum lead", int'(line_mark), 1);
    run_cycles(20, 0);
    // R10 change geometry mid scan; R12 start while busy
    pos_tag = "R10";
    set_geom(70, 9, 1, 1, 1);
    @(negedge clk); start = 1'b1; pix_en = 1'b1;
    @(negedge clk); start = 1'b0;
    pos_tag = "R12";
    run_cycles(5, 0);
    pos_tag = "R10";
    run_to_idle(0);
    chk("R4", "busy after full stack", int'(busy), 0);

    // Irregular pixel ticks
    pos_tag = "R4";
    set_geom(50, 8, 2, 2, 3);
    pulse_start();
    run_to_idle(1);

    // Sparse ticks, long lead
    set_geom(100, 3, 1, 2, 1);
    pulse_start();
    run_to_idle(2);

    // R11 stop mid line
    set_geom(46, 6, 4, 4, 2);
    pulse_start();
    run_cycles(75, 0);
    pos_tag = "R11";
    @(negedge clk); stop = 1'b1; pix_en = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R11", "busy right after stop", int'(busy), 1);
    run_to_idle(0);
    chk("R11", "busy after stopped line", int'(busy), 0);
    run_cycles(60, 0);

    // R11 stop on the final tick of a line
    pos_tag = "R4";
    pulse_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      pix_en = 1'b1;
      if (m_line == 1 && m_pix == 46 + 6 + 4 - 1) begin
        stop = 1'b1;
        break;
      end
    end
    pos_tag = "R11";
    @(negedge clk);
    stop = 1'b0; pix_en = 1'b1;
    chk("R11", "busy after stop at line end", int'(busy), 0);
    chk("R11", "pix_pos after stop at line end", int'(pix_pos), 0);
    run_cycles(60, 0);
    pix_en = 1'b0;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule